// File: doc/BRIEF.md
# Folded-Array Integer Squarer

This block is combinational. It squares an unsigned K-bit operand and returns the full 2K-bit result. It does not generate every cross term of a general K by K multiplier. Instead it folds the partial-product matrix with three rules:

- Each self-product bit reduces to the operand bit itself.
- Each mirrored pair of cross terms collapses to one AND term that sits one column higher.
- In every even column, the self bit and the neighbouring cross term are exchanged for an inhibited bit in that column and a carried AND term in the next column.

The folded rows are compressed by a chain of carry-save stages built from full-adder cells. A ripple row of the same cells then resolves the sum.

The same hardware also multiplies. A select input switches the block to product mode. In that mode two squarer cores work side by side. One squares the sum of the operands and the other squares the magnitude of their difference. The quarter of the gap between the two squares is the product. The division by four is an exact drop of the two lowest bits, because both squares share the same parity pattern. A parameter keeps or removes the neighbour-exchange rule, so the two array shapes can be compared in one build.

Top module: `fold_squarer`

## Requirements
- R1: With `mul_sel` = 0 (square mode) the result equals `a` × `a` for every value of `a`, with all 2K bits kept.
- R2: In square mode, result bit 0 always equals bit 0 of `a`.
- R3: In square mode, result bit 1 is always 0.
- R4: With `mul_sel` = 1 (product mode) the result equals `a` × `b`.
- R5: Product mode gives the same correct result whether `a` is above, below or equal to `b`.
- R6: In square mode, the value on `b` has no effect on the result.
- R7: A zero operand gives a zero result in either mode. All-ones operands give (2^K − 1)² in either mode, with no truncation.
- R8: The variant with the neighbour exchange (`MERGE` = 1) and the variant without it (`MERGE` = 0) give identical results for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | K | Operand to square; first factor in product mode |
| b | input | K | Second factor in product mode; ignored in square mode |
| mul_sel | input | 1 | 0 selects square mode, 1 selects product mode |
| result | output | 2K | Square of `a`, or product `a` × `b` |

## Verification
The block holds no state. A misplaced folded term or a miswired compressor cell therefore shows up at `result` in the same cycle as the operand that exercises it, and it does so for only a subset of operand values. For this reason square mode is swept over every possible operand, and each sweep point is checked against both array variants. In product mode a fault in the difference path or the exact-quarter step gives errors that depend on the ordering of the operands. The bench therefore drives mirrored pairs, equal pairs and extreme values alongside random pairs.

// File: rtl/fsq_pkg.sv
// Shared definitions for the folded squarer.
// Assumes: operand widths of at least 2 bits.
package fsq_pkg;

    // Encoding of the mode select input.
    typedef enum logic {
        MODE_SQUARE  = 1'b0,
        MODE_PRODUCT = 1'b1
    } fsq_mode_e;

    // Width of a full square of an n-bit operand.
    function automatic int sq_width(input int n);
        return 2 * n;
    endfunction

endpackage

// File: rtl/fsq_fa.sv
// One-bit full adder cell used by every compression stage.
// Assumes: nothing; purely combinational.
module fsq_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry.
    assign s  = x ^ y ^ ci;
    assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/fsq_pp_rows.sv
// Builds the folded partial-product rows of an N-bit square.
// Row i holds the self term of bit i at column 2i and the cross terms
// x_i & x_j (j > i) at column i+j+1. With MERGE set, the self term of
// bit i and the cross term of bits i-1,i (both in column 2i) are
// exchanged for x_i & ~x_(i-1) in column 2i plus x_i & x_(i-1) in
// column 2i+1, which removes one bit from each even column.
// Assumes: N >= 3.
module fsq_pp_rows #(
    parameter int N     = 9,
    parameter bit MERGE = 1'b1,
    localparam int W    = fsq_pkg::sq_width(N)
) (
    input  logic [N-1:0]        x,
    output logic [N-1:0][W-1:0] rows
);
    generate
        if (MERGE) begin : g_merge
            // Folded rows with the even-column neighbour exchange.
            always_comb begin
                rows = '0;
                rows[0][0] = x[0];
                for (int j = 2; j < N; j++) begin
                    rows[0][j+1] = x[0] & x[j];
                end
                for (int i = 1; i < N; i++) begin
                    rows[i][2*i]   = x[i] & ~x[i-1];
                    rows[i][2*i+1] = x[i] & x[i-1];
                    for (int j = i + 2; j < N; j++) begin
                        rows[i][i+j+1] = x[i] & x[j];
                    end
                end
            end
        end else begin : g_plain
            // Folded rows with self terms and shifted cross terms only.
            always_comb begin
                rows = '0;
                for (int i = 0; i < N; i++) begin
                    rows[i][2*i] = x[i];
                    for (int j = i + 1; j < N; j++) begin
                        rows[i][i+j+1] = x[i] & x[j];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fsq_reduce.sv
// Sums R rows of W bits: a chain of carry-save stages of full-adder
// cells, then a ripple row of the same cells.
// Assumes: R >= 3 and the true sum fits in W bits.
module fsq_reduce #(
    parameter int R = 9,
    parameter int W = 18
) (
    input  logic [R-1:0][W-1:0] rows,
    output logic [W-1:0]        total
);
    logic [R-2:0][W-1:0] ps;
    logic [R-2:0][W-1:0] pc;
    logic [R-2:0]        top_co;
    logic [W:0]          rc;

    // First pair of rows enters the chain unchanged.
    assign ps[0]     = rows[0];
    assign pc[0]     = rows[1];
    assign top_co[0] = 1'b0;

    genvar st, bt;
    generate
        for (st = 1; st <= R - 2; st++) begin : g_stage
            logic [W-1:0] co;
            for (bt = 0; bt < W; bt++) begin : g_bit
                fsq_fa u_fa (
                    .x (ps[st-1][bt]),
                    .y (pc[st-1][bt]),
                    .ci(rows[st+1][bt]),
                    .s (ps[st][bt]),
                    .co(co[bt])
                );
            end
            // Carries move up one column; the top one must stay zero.
            assign pc[st]     = {co[W-2:0], 1'b0};
            assign top_co[st] = co[W-1];
        end

        assign rc[0] = 1'b0;
        for (bt = 0; bt < W; bt++) begin : g_ripple
            fsq_fa u_fa (
                .x (ps[R-2][bt]),
                .y (pc[R-2][bt]),
                .ci(rc[bt]),
                .s (total[bt]),
                .co(rc[bt+1])
            );
        end
    endgenerate

    // R1: no carry may leave the W-bit field anywhere in the tree.
    always_comb begin
        p_no_overflow_r1: assert (top_co == '0 && rc[W] == 1'b0)
            else $error("carry lost out of the top column");
    end
endmodule

// File: rtl/fsq_core.sv
// Unsigned N-bit squarer: folded rows feeding the adder-cell reducer.
// Assumes: N >= 3.
module fsq_core #(
    parameter int N     = 9,
    parameter bit MERGE = 1'b1,
    localparam int W    = fsq_pkg::sq_width(N)
) (
    input  logic [N-1:0] x,
    output logic [W-1:0] sq
);
    logic [N-1:0][W-1:0] rows;

    fsq_pp_rows #(.N(N), .MERGE(MERGE)) u_rows (
        .x   (x),
        .rows(rows)
    );

    fsq_reduce #(.R(N), .W(W)) u_red (
        .rows (rows),
        .total(sq)
    );

    // R2, R3: a square's low bits follow the operand's low bit.
    always_comb begin
        p_lsb_follows_r2: assert (sq[0] == x[0])
            else $error("square bit 0 differs from operand bit 0");
        p_bit1_zero_r3: assert (sq[1] == 1'b0)
            else $error("square bit 1 is set");
    end
endmodule

// File: rtl/fsq_operand_prep.sv
// Chooses what the two squarer cores see. Square mode: core 0 gets a
// and core 1 gets zero. Product mode: core 0 gets a+b and core 1 gets
// |a-b|.
// Assumes: unsigned operands.
module fsq_operand_prep #(
    parameter int K = 8
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    input  logic         mul_sel,
    output logic [K:0]   sq_in0,
    output logic [K:0]   sq_in1
);
    logic [K:0] opsum;
    logic [K:0] opdif;

    // Widened sum and magnitude of the difference.
    always_comb begin
        opsum = {1'b0, a} + {1'b0, b};
        opdif = (a >= b) ? {1'b0, a - b} : {1'b0, b - a};
    end

    // Per-mode routing to the two cores.
    always_comb begin
        if (mul_sel == fsq_pkg::MODE_PRODUCT) begin
            sq_in0 = opsum;
            sq_in1 = opdif;
        end else begin
            sq_in0 = {1'b0, a};
            sq_in1 = '0;
        end
    end
endmodule

// File: rtl/fold_squarer.sv
// Top level: squares a, or multiplies a by b through two squares.
// Assumes: K >= 2; the result is purely combinational.
module fold_squarer #(
    parameter int K     = 8,
    parameter bit MERGE = 1'b1,
    localparam int CW   = K + 1,
    localparam int SW   = fsq_pkg::sq_width(CW),
    localparam int RW   = fsq_pkg::sq_width(K)
) (
    input  logic [K-1:0]  a,
    input  logic [K-1:0]  b,
    input  logic          mul_sel,
    output logic [RW-1:0] result
);
    logic [CW-1:0] sq_in0;
    logic [CW-1:0] sq_in1;
    logic [SW-1:0] sq_hi;
    logic [SW-1:0] sq_lo;
    logic [SW-1:0] quad;

    fsq_operand_prep #(.K(K)) u_prep (
        .a      (a),
        .b      (b),
        .mul_sel(mul_sel),
        .sq_in0 (sq_in0),
        .sq_in1 (sq_in1)
    );

    fsq_core #(.N(CW), .MERGE(MERGE)) u_sq_hi (
        .x (sq_in0),
        .sq(sq_hi)
    );

    fsq_core #(.N(CW), .MERGE(MERGE)) u_sq_lo (
        .x (sq_in1),
        .sq(sq_lo)
    );

    // Difference of squares, then exact quarter or direct square.
    always_comb begin
        quad = sq_hi - sq_lo;
        if (mul_sel == fsq_pkg::MODE_PRODUCT) begin
            result = quad[SW-1:2];
        end else begin
            result = sq_hi[RW-1:0];
        end
    end

    // R4: the squares differ by a multiple of four with no borrow.
    // R6: in square mode the second core sits at zero, the first fits.
    always_comb begin
        if (mul_sel == fsq_pkg::MODE_PRODUCT) begin
            p_exact_quarter_r4: assert (quad[1:0] == 2'b00 && sq_hi >= sq_lo)
                else $error("difference of squares not an exact quarter");
        end else begin
            p_second_idle_r6: assert (sq_lo == '0 && sq_hi[SW-1:RW] == '0)
                else $error("square mode disturbed by second operand");
        end
    end
endmodule

// File: tb/tb_fold_squarer.sv
`timescale 1ns/1ps
module tb_fold_squarer;
    localparam int K = 8;
    localparam int W = 2 * K;

    typedef struct {
        logic [K-1:0] a;
        logic [K-1:0] b;
        logic         mode;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [K-1:0] a = '0;
    logic [K-1:0] b = '0;
    logic         mul_sel = 1'b0;
    logic [W-1:0] result;
    logic [W-1:0] result_plain;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    fold_squarer #(.K(K), .MERGE(1'b1)) dut (
        .a(a), .b(b), .mul_sel(mul_sel), .result(result)
    );

    fold_squarer #(.K(K), .MERGE(1'b0)) dut_plain (
        .a(a), .b(b), .mul_sel(mul_sel), .result(result_plain)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: apply operands at the falling edge, queue the expected value.
    task automatic drive(input int av, input int bv, input bit mode, input string tag);
        item_t it;
        int    e;
        @(negedge clk);
        a       = av[K-1:0];
        b       = bv[K-1:0];
        mul_sel = mode;
        e = mode ? (av * bv) : (av * av);
        it.a = av[K-1:0]; it.b = bv[K-1:0]; it.mode = mode;
        it.exp = e[W-1:0]; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare at the next rising edge, well after inputs settle.
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, result, it.exp);
            check("R8 plain variant", result_plain, it.exp);
            if (!it.mode) begin
                check("R2 bit0", {{(W-1){1'b0}}, result[0]}, {{(W-1){1'b0}}, it.a[0]});
                check("R3 bit1", {{(W-1){1'b0}}, result[1]}, '0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle zero", result, '0);

        // R7: extremes in both modes.
        drive(0, 0, 1'b0, "R7 square zero");
        drive(0, 200, 1'b1, "R7 product zero");
        drive(255, 0, 1'b0, "R7 square max");
        drive(255, 255, 1'b1, "R7 product max");

        // R1: every operand in square mode.
        for (int v = 0; v < (1 << K); v++) begin
            drive(v, 0, 1'b0, "R1 square sweep");
        end

        // R6: b varies while a stays fixed.
        for (int v = 0; v < 32; v++) begin
            drive(173, v * 8 + 3, 1'b0, "R6 b ignored");
        end

        // R5: mirrored and equal pairs.
        for (int v = 0; v < 64; v++) begin
            drive(v * 4 + 1, 250 - v * 3, 1'b1, "R5 a vs b");
            drive(250 - v * 3, v * 4 + 1, 1'b1, "R5 b vs a");
            drive(v * 4 + 2, v * 4 + 2, 1'b1, "R5 equal");
        end

        // R4: random products.
        for (int n = 0; n < 1500; n++) begin
            drive($urandom_range(0, 255), $urandom_range(0, 255), 1'b1, "R4 product");
        end

        // R4, R1: interleaved mode switching.
        for (int n = 0; n < 200; n++) begin
            drive($urandom_range(0, 255), $urandom_range(0, 255), n[0], "R4 mode mix");
        end

        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule